// File: doc/BRIEF.md
# Color-Banked Parallel Memory Crossbar

This block sits between a group of parallel soft-decoder processors and a stack of RAM banks that holds one word per trellis element. The elements are not spread over the banks by a fixed rule. Instead, every element carries a bank number, called its color, and that color is chosen offline so that the processors never meet on the same bank. This must hold both when they walk the trellis in natural order and when they walk it in interleaved order. Each processor owns a small color table with one half for each order. The block also holds a loadable copy of the interleaver permutation.

All processors share one step counter. On every cycle with `run` high, processor p works on element p·DEPTH+step in natural order, or on element π(p·DEPTH+step) in interleaved order. In the same cycle the block looks up the element's color, computes the word address, which is the element index modulo DEPTH, and sends address and write data to that bank. The read word comes back through a selector whose bank number is delayed to match the RAM. Processor p may be wired to only the first PBANKS[p] banks. If two processors ever reach the same bank in one step, a sticky flag is raised.

Top module: `cbx_xbar`

## Requirements
- R1: After reset, `rd_vld` and `collision` are 0 and the step counter is 0, so the first run step accesses step 0.
- R2: When `ilv`=0, processor p accesses element p·DEPTH+step. It uses bank `table[p][0][step]` at word address step. The table entry index is {tbl_ilv, tbl_idx}, and tbl_ilv=0 selects the natural half.
- R3: When `ilv`=1, processor p accesses element k=π(p·DEPTH+step). It uses bank `table[p][1][step]` at word address k mod DEPTH. π is written through `pi_addr`/`pi_val`.
- R4: The step counter advances by one on every cycle with `run`=1 and wraps from DEPTH-1 to 0. It holds while `run`=0.
- R5: With `wr_en[p]`=1 in a run step, `wr_data` slice p is stored in processor p's element. A read in the same step returns the element's previous contents.
- R6: `rd_data` and `rd_vld`=1 appear two clock edges after the edge that samples a run step. Steps may be issued back to back, and `rd_vld` is 0 two edges after an idle cycle.
- R7: `collision` becomes 1 when two processors select the same bank in one run step. It stays 1 until reset.
- R8: `wr_en` has no effect while `run`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Issue one access step for all processors |
| ilv | input | 1 | Access order: 0 natural, 1 interleaved |
| wr_en | input | NPROC | Per-processor write enable |
| wr_data | input | NPROC·DW | Per-processor write word, processor p in slice p |
| rd_data | output | NPROC·DW | Per-processor read word, processor p in slice p |
| rd_vld | output | 1 | Read words valid |
| collision | output | 1 | Sticky bank-conflict flag |
| tbl_we | input | 1 | Color table write strobe |
| tbl_proc | input | log2 NPROC | Processor whose table is written |
| tbl_ilv | input | 1 | Table half: 0 natural, 1 interleaved |
| tbl_idx | input | log2 DEPTH | Table entry (step) |
| tbl_color | input | log2 NBANK | Bank color to store |
| pi_we | input | 1 | Permutation write strobe |
| pi_addr | input | log2(NPROC·DEPTH) | Permutation input index |
| pi_val | input | log2(NPROC·DEPTH) | Permuted element index |

## Verification
The bench colors a 32-element trellis greedily under an affine permutation, loads the tables, and then streams full passes in both orders against an arithmetic model of the element store. It writes in interleaved order while it reads, so a design that read after its write would return the new words instead of the old ones. It starts one pass mid-range, so a counter that failed to wrap or that moved during idle cycles would fetch the wrong elements. A wrong table half or an unshifted select delay would route words from the wrong bank. Idle cycles with `wr_en` held high would corrupt the stored data in a design that ignored `run`. A deliberately clashing table entry must set the flag, and the flag must stay set until reset.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
    typedef enum logic {
        ORD_NAT = 1'b0,
        ORD_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/cbx_ram.sv
module cbx_ram #(
    parameter int W = 8,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [N];

    // registered read, returns the word held before a same-cycle write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cbx_arb.sv
module cbx_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         multi
);
    // lowest-numbered requester owns the bank
    always_comb begin
        gnt   = req & (~req + N'(1));
        multi = |(req & ~gnt);
    end
endmodule

// File: rtl/cbx_lane.sv
module cbx_lane #(
    parameter int PIDX  = 0,
    parameter int DEPTH = 8,
    parameter int NBANK = 8,
    parameter int NELEM = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(NBANK),
    localparam int IW = $clog2(NELEM)
) (
    input  logic          clk,
    input  logic          tbl_we,
    input  logic [AW:0]   tbl_addr,
    input  logic [CW-1:0] tbl_color,
    input  logic          pi_we,
    input  logic [IW-1:0] pi_addr,
    input  logic [IW-1:0] pi_val,
    input  logic [AW-1:0] step,
    input  logic          ilv,
    output logic [CW-1:0] color,
    output logic [IW-1:0] elem
);
    // color table: upper half serves the interleaved order
    cbx_ram #(.W(CW), .N(2 << AW)) u_col (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_color),
        .raddr ({ilv, step}),
        .rdata (color)
    );

    // private copy of the permutation, indexed by this lane's natural element
    cbx_ram #(.W(IW), .N(NELEM)) u_pi (
        .clk   (clk),
        .we    (pi_we),
        .waddr (pi_addr),
        .wdata (pi_val),
        .raddr (IW'(PIDX * DEPTH) + IW'(step)),
        .rdata (elem)
    );
endmodule

// File: rtl/cbx_xbar.sv
module cbx_xbar
    import cbx_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int DEPTH = 8,
    parameter int NBANK = 8,
    parameter int DW    = 8,
    parameter int PBANKS [NPROC] = '{default: NBANK},
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(NBANK),
    localparam int NELEM = NPROC * DEPTH,
    localparam int IW    = $clog2(NELEM),
    localparam int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                ilv,
    input  logic [NPROC-1:0]    wr_en,
    input  logic [NPROC*DW-1:0] wr_data,
    output logic [NPROC*DW-1:0] rd_data,
    output logic                rd_vld,
    output logic                collision,
    input  logic                tbl_we,
    input  logic [PW-1:0]       tbl_proc,
    input  logic                tbl_ilv,
    input  logic [AW-1:0]       tbl_idx,
    input  logic [CW-1:0]       tbl_color,
    input  logic                pi_we,
    input  logic [IW-1:0]       pi_addr,
    input  logic [IW-1:0]       pi_val
);
    typedef struct packed {
        logic [AW-1:0]               step;
        logic                        act1;
        logic                        ilv1;
        logic [AW-1:0]               step1;
        logic [NPROC-1:0]            we1;
        logic [NPROC-1:0][DW-1:0]    wd1;
        logic                        act2;
        logic [NPROC-1:0][CW-1:0]    sel2;
        logic                        coll;
    } st_t;

    st_t s_d, s_q;

    logic [CW-1:0]    col1  [NPROC];
    logic [IW-1:0]    elem1 [NPROC];
    logic [AW-1:0]    addr1 [NPROC];
    logic [NPROC-1:0] req   [NBANK];
    logic [NPROC-1:0] gnt   [NBANK];
    logic [NBANK-1:0] multi;
    logic             bk_we   [NBANK];
    logic [AW-1:0]    bk_addr [NBANK];
    logic [DW-1:0]    bk_wd   [NBANK];
    logic [DW-1:0]    bk_rd   [NBANK];
    logic [DW-1:0]    rd_lane [NPROC];

    // per-processor color and permutation lookup (stage 1)
    for (genvar p = 0; p < NPROC; p++) begin : g_lane
        cbx_lane #(
            .PIDX  (p),
            .DEPTH (DEPTH),
            .NBANK (NBANK),
            .NELEM (NELEM)
        ) u_lane (
            .clk       (clk),
            .tbl_we    (tbl_we && (tbl_proc == PW'(p))),
            .tbl_addr  ({tbl_ilv, tbl_idx}),
            .tbl_color (tbl_color),
            .pi_we     (pi_we),
            .pi_addr   (pi_addr),
            .pi_val    (pi_val),
            .step      (s_q.step),
            .ilv       (ilv),
            .color     (col1[p]),
            .elem      (elem1[p])
        );
    end

    // word address and bank requests, limited to each lane's wired banks
    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            addr1[p] = (s_q.ilv1 == ORD_ILV) ? elem1[p][AW-1:0] : s_q.step1;
        end
        for (int b = 0; b < NBANK; b++) begin
            req[b] = '0;
            for (int p = 0; p < NPROC; p++) begin
                if (s_q.act1 && (b < PBANKS[p]) && (col1[p] == CW'(b))) req[b][p] = 1'b1;
            end
        end
    end

    // bank stack (stage 2)
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cbx_arb #(.N(NPROC)) u_arb (
            .req   (req[b]),
            .gnt   (gnt[b]),
            .multi (multi[b])
        );
        cbx_ram #(.W(DW), .N(DEPTH)) u_ram (
            .clk   (clk),
            .we    (bk_we[b]),
            .waddr (bk_addr[b]),
            .wdata (bk_wd[b]),
            .raddr (bk_addr[b]),
            .rdata (bk_rd[b])
        );
    end

    // forward switch: granted lane drives its bank
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            bk_we[b]   = 1'b0;
            bk_addr[b] = '0;
            bk_wd[b]   = '0;
            for (int p = 0; p < NPROC; p++) begin
                if (gnt[b][p]) begin
                    bk_we[b]   = s_q.we1[p];
                    bk_addr[b] = addr1[p];
                    bk_wd[b]   = s_q.wd1[p];
                end
            end
        end
    end

    // return selector driven by the delayed color
    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            rd_lane[p] = '0;
            for (int b = 0; b < NBANK; b++) begin
                if ((b < PBANKS[p]) && (s_q.sel2[p] == CW'(b))) rd_lane[p] = bk_rd[b];
            end
            rd_data[p*DW +: DW] = rd_lane[p];
        end
    end

    // next state
    always_comb begin
        s_d = s_q;
        if (run) s_d.step = (s_q.step == AW'(DEPTH - 1)) ? '0 : s_q.step + AW'(1);
        s_d.act1  = run;
        s_d.ilv1  = ilv;
        s_d.step1 = s_q.step;
        s_d.we1   = wr_en & {NPROC{run}};
        for (int p = 0; p < NPROC; p++) begin
            s_d.wd1[p]  = wr_data[p*DW +: DW];
            s_d.sel2[p] = col1[p];
        end
        s_d.act2 = s_q.act1;
        s_d.coll = s_q.coll | (|multi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_vld    = s_q.act2;
    assign collision = s_q.coll;
endmodule

// File: rtl/cbx_xbar_chk.sv
module cbx_xbar_chk #(
    parameter int AW    = 3,
    parameter int DEPTH = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          rd_vld,
    input logic          collision,
    input logic [AW-1:0] step
);
    a_r6_vld_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ##1 rd_vld);

    a_r6_no_vld_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ##1 !rd_vld);

    a_r7_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> collision);

    a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (step == (($past(step) == AW'(DEPTH - 1)) ? '0 : $past(step) + AW'(1))));

    a_r4_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(step));
endmodule

bind cbx_xbar cbx_xbar_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .rd_vld    (rd_vld),
    .collision (collision),
    .step      (s_q.step)
);

// File: tb/tb_cbx_xbar.sv
`timescale 1ns/1ps
module tb_cbx_xbar;
    localparam int P  = 4;
    localparam int D  = 8;
    localparam int NB = 8;
    localparam int DW = 8;
    localparam int NE = P * D;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run = 1'b0;
    logic            ilv = 1'b0;
    logic [P-1:0]    wr_en = '0;
    logic [P*DW-1:0] wr_data = '0;
    logic [P*DW-1:0] rd_data;
    logic            rd_vld;
    logic            collision;
    logic            tbl_we = 1'b0;
    logic [1:0]      tbl_proc = '0;
    logic            tbl_ilv = 1'b0;
    logic [2:0]      tbl_idx = '0;
    logic [2:0]      tbl_color = '0;
    logic            pi_we = 1'b0;
    logic [4:0]      pi_addr = '0;
    logic [4:0]      pi_val = '0;

    int checks = 0;
    int errors = 0;
    int mcnt = 0;
    int pi_t [NE];
    int pinv [NE];
    int color [NE];
    int model [NE];

    always #4 clk = ~clk;

    cbx_xbar dut (
        .clk, .rst_n, .run, .ilv, .wr_en, .wr_data, .rd_data, .rd_vld, .collision,
        .tbl_we, .tbl_proc, .tbl_ilv, .tbl_idx, .tbl_color, .pi_we, .pi_addr, .pi_val
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wval(input int k, input int key);
        return (k * key + 17 * key + 3) & 255;
    endfunction

    function automatic void build_coloring();
        for (int v = 0; v < NE; v++) begin
            bit used [NB];
            int mn;
            int mi;
            int u;
            for (int c = 0; c < NB; c++) used[c] = 1'b0;
            mn = v % D;
            mi = pinv[v] % D;
            for (int p = 0; p < P; p++) begin
                u = p * D + mn;
                if (u < v) used[color[u]] = 1'b1;
                u = pi_t[p * D + mi];
                if (u < v) used[color[u]] = 1'b1;
            end
            color[v] = 0;
            while (used[color[v]]) color[v]++;
        end
    endfunction

    task automatic load_tbl(input int p, input int o, input int m, input int c);
        @(negedge clk);
        tbl_we = 1'b1; tbl_proc = 2'(p); tbl_ilv = o[0]; tbl_idx = 3'(m); tbl_color = 3'(c);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // streams n steps back to back; checks words two edges after each step
    task automatic run_pass(input bit ord, input bit wr, input int key, input bit cd,
                            input int n, input string tag);
        int expd [D][P];
        int m0 = mcnt;
        for (int j = 0; j < n + 2; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                chk(rd_vld == 1'b1, {tag, " R6 rd_vld"}, int'(rd_vld), 1);
                if (cd) begin
                    for (int p = 0; p < P; p++)
                        chk(int'(rd_data[p*DW +: DW]) == expd[j-2][p], {tag, " rd_data"},
                            int'(rd_data[p*DW +: DW]), expd[j-2][p]);
                end
            end else begin
                chk(rd_vld == 1'b0, "R6 rd_vld idle", int'(rd_vld), 0);
            end
            if (j < n) begin
                int m = (m0 + j) % D;
                run = 1'b1;
                ilv = ord;
                for (int p = 0; p < P; p++) begin
                    int k = ord ? pi_t[p * D + m] : p * D + m;
                    expd[j][p] = model[k];
                    wr_en[p] = wr;
                    wr_data[p*DW +: DW] = 8'(wval(k, key));
                    if (wr) model[k] = wval(k, key);
                end
            end else begin
                run = 1'b0;
                wr_en = '0;
            end
        end
        mcnt = (m0 + n) % D;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int x = 0; x < NE; x++) begin
            pi_t[x] = (5 * x + 3) % NE;
            pinv[pi_t[x]] = x;
            model[x] = 0;
        end
        build_coloring();

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_vld == 1'b0, "R1 rd_vld after reset", int'(rd_vld), 0);
        chk(collision == 1'b0, "R1 collision after reset", int'(collision), 0);

        for (int x = 0; x < NE; x++) begin
            @(negedge clk);
            pi_we = 1'b1; pi_addr = 5'(x); pi_val = 5'(pi_t[x]);
        end
        @(negedge clk);
        pi_we = 1'b0;
        for (int p = 0; p < P; p++)
            for (int o = 0; o < 2; o++)
                for (int m = 0; m < D; m++)
                    load_tbl(p, o, m, color[o ? pi_t[p * D + m] : p * D + m]);

        // R1 R5: fill from step 0 in natural order (old contents unknown)
        run_pass(1'b0, 1'b1, 5, 1'b0, D, "R1 R5");
        // R2 R4: natural read after wrap
        run_pass(1'b0, 1'b0, 0, 1'b1, D, "R2 R4");
        // R3: interleaved read
        run_pass(1'b1, 1'b0, 0, 1'b1, D, "R3");
        // R5: interleaved write, reads must return previous words
        run_pass(1'b1, 1'b1, 11, 1'b1, D, "R5");
        run_pass(1'b0, 1'b0, 0, 1'b1, D, "R5 R2");

        // R8: write enables while idle must not disturb data or counter
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            run = 1'b0; ilv = i[0]; wr_en = '1; wr_data = {P{8'hAA}};
            if (i >= 2) chk(rd_vld == 1'b0, "R6 idle rd_vld", int'(rd_vld), 0);
        end
        run_pass(1'b0, 1'b0, 0, 1'b1, D, "R8 R4");

        // R4: start mid-range and wrap within an interleaved pass
        run_pass(1'b0, 1'b0, 0, 1'b1, 3, "R4");
        run_pass(1'b1, 1'b0, 0, 1'b1, D, "R4 R3");

        chk(collision == 1'b0, "R7 no false collision", int'(collision), 0);

        // R7: force processor 1 onto processor 0's bank
        load_tbl(1, 0, mcnt, color[mcnt]);
        @(negedge clk);
        run = 1'b1; ilv = 1'b0; wr_en = '0;
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(collision == 1'b1, "R7 collision set", int'(collision), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(collision == 1'b1, "R7 collision sticky", int'(collision), 1);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(collision == 1'b0, "R7 R1 collision cleared by reset", int'(collision), 0);
        chk(rd_vld == 1'b0, "R1 rd_vld after second reset", int'(rd_vld), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule